// File: doc/BRIEF.md
# Peripheral Bus Version Adapter

This block joins a peripheral-bus manager segment that has wait, error, byte-lane and protection signals to a subordinate segment of the oldest two-phase kind. That older segment has only select, enable, direction, address, write data and read data. The adapter passes each transfer through with its timing unchanged. It creates constant values for the handshake and error returns that the subordinate side cannot supply. It also decides what happens to a write whose byte lanes do not cover the whole word, because the subordinate side can only write full words.

A parameter chooses how partial-lane writes are handled. In the blocking policy, the write never reaches the subordinate side and the manager receives an error in the access cycle. In the forwarding policy, the write goes through as a full-word write and is only counted. Two saturating counters are always present. One counts partial-lane writes and the other counts accesses that carry a non-default protection tag. Both are visible on side outputs and are cleared by a one-cycle pulse. Protection information is dropped at the seam.

Top module: `apb_ver_bridge`

## Requirements
- R1: `up_ready` is 1 in every cycle, including during reset, so every upstream transfer ends after one setup cycle and one access cycle.
- R2: `up_err` is 0 in every cycle in which the transfer is forwarded downstream: all reads, and all writes whose `up_strb` is all ones.
- R3: For a forwarded transfer, `dn_sel`, `dn_en`, `dn_wr`, `dn_addr` and `dn_wdata` equal the upstream select, enable, direction, address and write data in the same cycle, with no register in the path.
- R4: With `BLOCK_PARTIAL`=1, a write whose `up_strb` is not all ones (an all-zero strobe included) keeps `dn_sel` and `dn_en` at 0 in both its cycles. `up_err` is 0 in its setup cycle and 1 in its access cycle.
- R5: With `BLOCK_PARTIAL`=0, a partial-strobe write is forwarded downstream as an ordinary full-word write carrying all of `up_wdata`, and `up_err` stays 0.
- R6: `up_rdata` equals `dn_rdata` combinationally in the access cycle of a read (`up_sel`=1, `up_en`=1, `up_wr`=0). It is 0 in every other cycle.
- R7: `cnt_partial` increases by one at the clock edge that ends the access cycle of each partial-strobe write, under either policy. The new value is visible after that edge.
- R8: `cnt_prot` increases by one at the edge that ends the access cycle of each transfer, read or write, whose `up_prot` differs from `PROT_DEFAULT` (default 3'b000). Transfers with the default tag leave it unchanged.
- R9: Each counter stops at its all-ones value (2^`CNT_W`-1) and does not wrap.
- R10: A 1 on `cnt_clr` at a clock edge sets both counters to 0 at that edge, even when an increment is due at the same edge.
- R11: After reset both counters read 0 and `up_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_sel | input | 1 | Upstream select |
| up_en | input | 1 | Upstream enable (access phase) |
| up_wr | input | 1 | Upstream direction, 1 = write |
| up_addr | input | ADDR_W | Upstream address |
| up_wdata | input | DATA_W | Upstream write data |
| up_strb | input | DATA_W/8 | Upstream byte-lane enables |
| up_prot | input | PROT_W | Upstream protection tag |
| up_rdata | output | DATA_W | Read data returned upstream |
| up_ready | output | 1 | Ready returned upstream, constant 1 |
| up_err | output | 1 | Error returned upstream |
| dn_sel | output | 1 | Downstream select |
| dn_en | output | 1 | Downstream enable |
| dn_wr | output | 1 | Downstream direction |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | DATA_W | Downstream write data, always a full word |
| dn_rdata | input | DATA_W | Read data from the downstream subordinate |
| cnt_clr | input | 1 | One-cycle clear for both counters |
| cnt_partial | output | CNT_W | Count of partial-strobe writes |
| cnt_prot | output | CNT_W | Count of non-default protection accesses |

## Verification
The bench drives the same bus into two instances side by side. The first is built with `BLOCK_PARTIAL`=1 and `CNT_W`=4. The second is built with `BLOCK_PARTIAL`=0 and the default 16-bit counters. Because the first instance's counters saturate after fifteen events, a short burst of partial writes with a non-default tag reaches the saturation limit. The same burst shows the second instance still counting past that point. Running both policies on identical stimulus places the blocked error response and the forwarded full-word write on the same transfer, so the two can be compared cycle for cycle.

// File: rtl/apb_ver_bridge_pkg.sv
package apb_ver_bridge_pkg;

   typedef enum logic {
      POL_FORWARD = 1'b0,
      POL_BLOCK   = 1'b1
   } partial_pol_e;

   function automatic partial_pol_e pol_from_bit(input bit b);
      return b ? POL_BLOCK : POL_FORWARD;
   endfunction

endpackage

// File: rtl/apb_ver_gate.sv
module apb_ver_gate
   import apb_ver_bridge_pkg::*;
#(
   parameter int           ADDR_W        = 12,
   parameter int           DATA_W        = 32,
   parameter int           PROT_W        = 3,
   parameter bit           BLOCK_PARTIAL = 1'b1,
   parameter [PROT_W-1:0]  PROT_DEFAULT  = '0,
   localparam int          STRB_W        = DATA_W / 8
) (
   input  logic              up_sel,
   input  logic              up_en,
   input  logic              up_wr,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [DATA_W-1:0] up_wdata,
   input  logic [STRB_W-1:0] up_strb,
   input  logic [PROT_W-1:0] up_prot,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_err,
   output logic              dn_sel,
   output logic              dn_en,
   output logic              dn_wr,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              evt_partial,
   output logic              evt_prot
);

   localparam partial_pol_e POLICY = pol_from_bit(BLOCK_PARTIAL);

   logic is_partial;
   logic in_access;

   assign is_partial = up_wr && (up_strb != {STRB_W{1'b1}});
   assign in_access  = up_sel && up_en;

   // fields that never depend on the policy
   assign dn_wr    = up_wr;
   assign dn_addr  = up_addr;
   assign dn_wdata = up_wdata;

   generate
      if (POLICY == POL_BLOCK) begin : g_block
         logic hold_off;
         assign hold_off = up_sel && is_partial;
         assign dn_sel   = up_sel && !hold_off;
         assign dn_en    = up_en  && !hold_off;
         assign up_err   = in_access && is_partial;
      end else begin : g_forward
         assign dn_sel = up_sel;
         assign dn_en  = up_en;
         assign up_err = 1'b0;
      end
   endgenerate

   always_comb begin
      up_rdata = '0;
      if (in_access && !up_wr) up_rdata = dn_rdata;
   end

   assign evt_partial = in_access && is_partial;
   assign evt_prot    = in_access && (up_prot != PROT_DEFAULT);

endmodule

// File: rtl/apb_ver_sat_cnt.sv
module apb_ver_sat_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] value
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != TOP)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign value = cnt_q;

endmodule

// File: rtl/apb_ver_bridge.sv
module apb_ver_bridge
   import apb_ver_bridge_pkg::*;
#(
   parameter int           ADDR_W        = 12,
   parameter int           DATA_W        = 32,
   parameter int           PROT_W        = 3,
   parameter int           CNT_W         = 16,
   parameter bit           BLOCK_PARTIAL = 1'b1,
   parameter [PROT_W-1:0]  PROT_DEFAULT  = '0,
   localparam int          STRB_W        = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_sel,
   input  logic              up_en,
   input  logic              up_wr,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [DATA_W-1:0] up_wdata,
   input  logic [STRB_W-1:0] up_strb,
   input  logic [PROT_W-1:0] up_prot,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_ready,
   output logic              up_err,
   output logic              dn_sel,
   output logic              dn_en,
   output logic              dn_wr,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata,
   input  logic              cnt_clr,
   output logic [CNT_W-1:0]  cnt_partial,
   output logic [CNT_W-1:0]  cnt_prot
);

   localparam int N_CNT = 2;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("apb_ver_bridge: DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("apb_ver_bridge: ADDR_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("apb_ver_bridge: CNT_W must lie in 1..32");
      end
      if (PROT_W < 1) begin : g_bad_prot_w
         $error("apb_ver_bridge: PROT_W must be at least 1");
      end
   endgenerate

   logic             evt_partial;
   logic             evt_prot;
   logic [N_CNT-1:0] evt_vec;
   logic [CNT_W-1:0] cnt_vals [N_CNT];

   // the subordinate side cannot stall, so the manager never waits
   assign up_ready = 1'b1;

   apb_ver_gate #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .PROT_W       (PROT_W),
      .BLOCK_PARTIAL(BLOCK_PARTIAL),
      .PROT_DEFAULT (PROT_DEFAULT)
   ) u_gate (
      .up_sel     (up_sel),
      .up_en      (up_en),
      .up_wr      (up_wr),
      .up_addr    (up_addr),
      .up_wdata   (up_wdata),
      .up_strb    (up_strb),
      .up_prot    (up_prot),
      .up_rdata   (up_rdata),
      .up_err     (up_err),
      .dn_sel     (dn_sel),
      .dn_en      (dn_en),
      .dn_wr      (dn_wr),
      .dn_addr    (dn_addr),
      .dn_wdata   (dn_wdata),
      .dn_rdata   (dn_rdata),
      .evt_partial(evt_partial),
      .evt_prot   (evt_prot)
   );

   assign evt_vec = {evt_prot, evt_partial};

   generate
      for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
         apb_ver_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (cnt_clr),
            .inc  (evt_vec[i]),
            .value(cnt_vals[i])
         );
      end
   endgenerate

   assign cnt_partial = cnt_vals[0];
   assign cnt_prot    = cnt_vals[1];

endmodule

// File: rtl/apb_ver_bridge_chk.sv
module apb_ver_bridge_chk #(
   parameter int           ADDR_W        = 12,
   parameter int           DATA_W        = 32,
   parameter int           PROT_W        = 3,
   parameter int           CNT_W         = 16,
   parameter bit           BLOCK_PARTIAL = 1'b1,
   localparam int          STRB_W        = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_sel,
   input logic              up_en,
   input logic              up_wr,
   input logic [ADDR_W-1:0] up_addr,
   input logic [STRB_W-1:0] up_strb,
   input logic              up_ready,
   input logic              up_err,
   input logic              dn_sel,
   input logic              dn_en,
   input logic              dn_wr,
   input logic [ADDR_W-1:0] dn_addr,
   input logic              cnt_clr,
   input logic [CNT_W-1:0]  cnt_partial,
   input logic [CNT_W-1:0]  cnt_prot
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic partial_wr;
   assign partial_wr = up_sel && up_wr && (up_strb != {STRB_W{1'b1}});

   // R1
   ready_high_chk: assert property (@(posedge clk) up_ready);

   // R2
   fwd_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_sel && dn_en) |-> !up_err);

   // R3
   fwd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_sel |-> (up_sel && dn_addr == up_addr && dn_wr == up_wr));

   // R4
   block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BLOCK_PARTIAL && partial_wr) |-> (!dn_sel && !dn_en));

   // R5
   fwd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!BLOCK_PARTIAL && up_sel) |-> (dn_sel && !up_err));

   // R7
   partial_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> cnt_partial >= $past(cnt_partial));

   // R9
   partial_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_partial == TOP && !cnt_clr) |=> cnt_partial == TOP);

   // R9
   prot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_prot == TOP && !cnt_clr) |=> cnt_prot == TOP);

   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt_partial == '0 && cnt_prot == '0));

endmodule

bind apb_ver_bridge apb_ver_bridge_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .PROT_W       (PROT_W),
   .CNT_W        (CNT_W),
   .BLOCK_PARTIAL(BLOCK_PARTIAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .up_sel     (up_sel),
   .up_en      (up_en),
   .up_wr      (up_wr),
   .up_addr    (up_addr),
   .up_strb    (up_strb),
   .up_ready   (up_ready),
   .up_err     (up_err),
   .dn_sel     (dn_sel),
   .dn_en      (dn_en),
   .dn_wr      (dn_wr),
   .dn_addr    (dn_addr),
   .cnt_clr    (cnt_clr),
   .cnt_partial(cnt_partial),
   .cnt_prot   (cnt_prot)
);

// File: tb/sim_apb_ver_bridge.sv
module sim_apb_ver_bridge;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam int SW = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          up_sel = 0, up_en = 0, up_wr = 0, cnt_clr = 0;
   logic [AW-1:0] up_addr = '0;
   logic [DW-1:0] up_wdata = '0;
   logic [SW-1:0] up_strb = '0;
   logic [2:0]    up_prot = '0;

   logic [DW-1:0] rd0, rd1, dr0, dr1, dwd0, dwd1;
   logic          rdy0, rdy1, err0, err1, ds0, ds1, de0, de1, dwr0, dwr1;
   logic [AW-1:0] da0, da1;
   logic [3:0]    cp0, cq0;
   logic [15:0]   cp1, cq1;

   // downstream subordinate model: read data from the address
   assign dr0 = 32'hA500_0000 ^ {20'h0, da0};
   assign dr1 = 32'hA500_0000 ^ {20'h0, da1};

   apb_ver_bridge #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(4), .BLOCK_PARTIAL(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_en(up_en), .up_wr(up_wr),
      .up_addr(up_addr), .up_wdata(up_wdata), .up_strb(up_strb), .up_prot(up_prot),
      .up_rdata(rd0), .up_ready(rdy0), .up_err(err0), .dn_sel(ds0), .dn_en(de0),
      .dn_wr(dwr0), .dn_addr(da0), .dn_wdata(dwd0), .dn_rdata(dr0),
      .cnt_clr(cnt_clr), .cnt_partial(cp0), .cnt_prot(cq0));

   apb_ver_bridge #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(16), .BLOCK_PARTIAL(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_en(up_en), .up_wr(up_wr),
      .up_addr(up_addr), .up_wdata(up_wdata), .up_strb(up_strb), .up_prot(up_prot),
      .up_rdata(rd1), .up_ready(rdy1), .up_err(err1), .dn_sel(ds1), .dn_en(de1),
      .dn_wr(dwr1), .dn_addr(da1), .dn_wdata(dwd1), .dn_rdata(dr1),
      .cnt_clr(cnt_clr), .cnt_partial(cp1), .cnt_prot(cq1));

   int checks = 0;
   int errors = 0;
   int e_p0 = 0, e_q0 = 0, e_p1 = 0, e_q1 = 0;

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_counts(input string tag);
      chk(cp0 == 4'(e_p0), {tag, " u0 partial"}, 64'(cp0), 64'(e_p0));
      chk(cq0 == 4'(e_q0), {tag, " u0 prot"},    64'(cq0), 64'(e_q0));
      chk(cp1 == 16'(e_p1), {tag, " u1 partial"}, 64'(cp1), 64'(e_p1));
      chk(cq1 == 16'(e_q1), {tag, " u1 prot"},    64'(cq1), 64'(e_q1));
   endtask

   function automatic int sat(input int v, input int top);
      return (v >= top) ? top : v;
   endfunction

   // one full transfer; checks both instances in setup, access and afterwards
   task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [SW-1:0] s, input logic [2:0] p, input logic clr_in_acc);
      logic part;
      logic [DW-1:0] exp_rd;
      part   = wr && (s != {SW{1'b1}});
      exp_rd = 32'hA500_0000 ^ {20'h0, a};
      @(negedge clk);
      up_sel = 1; up_en = 0; up_wr = wr; up_addr = a; up_wdata = d; up_strb = s; up_prot = p;
      #1;
      // setup phase
      chk(rdy0 && rdy1, "R1 ready setup", 64'({rdy0, rdy1}), 64'h3);
      chk(!err0 && !err1, "R2/R4 no err in setup", 64'({err0, err1}), 64'h0);
      chk(ds0 == !part, "R4 u0 setup sel", 64'(ds0), 64'(!part));
      chk(ds1 && !de1 && da1 == a && dwr1 == wr && dwd1 == d, "R3 u1 setup pass",
          64'({ds1, de1, da1}), 64'({1'b1, 1'b0, a}));
      chk(rd0 == '0 && rd1 == '0, "R6 rdata zero in setup", 64'({rd0, rd1}), 64'h0);
      @(negedge clk);
      up_en = 1; cnt_clr = clr_in_acc;
      #1;
      // access phase
      chk(rdy0 && rdy1, "R1 ready access", 64'({rdy0, rdy1}), 64'h3);
      if (part) begin
         chk(!ds0 && !de0 && err0, "R4 u0 blocked with err", 64'({ds0, de0, err0}), 64'h1);
         chk(ds1 && de1 && dwd1 == d && !err1, "R5 u1 full-word forward",
             64'({ds1, de1, err1}), 64'h6);
      end else begin
         chk(ds0 && de0 && da0 == a && dwd0 == d && !err0, "R2/R3 u0 forward",
             64'({ds0, de0, err0}), 64'h6);
         chk(ds1 && de1 && da1 == a && !err1, "R2/R3 u1 forward",
             64'({ds1, de1, err1}), 64'h6);
      end
      if (!wr) begin
         chk(rd0 == exp_rd, "R6 u0 read data", 64'(rd0), 64'(exp_rd));
         chk(rd1 == exp_rd, "R6 u1 read data", 64'(rd1), 64'(exp_rd));
      end else begin
         chk(rd0 == '0 && rd1 == '0, "R6 rdata zero on write", 64'({rd0, rd1}), 64'h0);
      end
      if (clr_in_acc) begin
         e_p0 = 0; e_q0 = 0; e_p1 = 0; e_q1 = 0;
      end else begin
         if (part) begin
            e_p0 = sat(e_p0 + 1, 15); e_p1 = sat(e_p1 + 1, 65535);
         end
         if (p != 3'b000) begin
            e_q0 = sat(e_q0 + 1, 15); e_q1 = sat(e_q1 + 1, 65535);
         end
      end
      @(negedge clk);
      up_sel = 0; up_en = 0; cnt_clr = 0;
      #1;
      chk(!err0 && !err1 && !ds0 && !ds1, "R4 idle after transfer",
          64'({err0, err1, ds0, ds1}), 64'h0);
   endtask

   task automatic t_reset;
      #1;
      chk(rdy0 && rdy1, "R1 ready during reset", 64'({rdy0, rdy1}), 64'h3);
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(!err0 && !err1, "R11 err low after reset", 64'({err0, err1}), 64'h0);
      chk_counts("R11 reset counters");
   endtask

   task automatic t_full_write;
      xfer(1'b1, 12'h010, 32'hDEAD_BEEF, 4'hF, 3'b000, 1'b0);
      chk_counts("R7/R8 full write default tag");
   endtask

   task automatic t_read;
      xfer(1'b0, 12'h3C4, 32'h0, 4'h0, 3'b000, 1'b0);
      chk_counts("R8 read default tag");
      xfer(1'b0, 12'h0A8, 32'h0, 4'h0, 3'b101, 1'b0);
      chk_counts("R8 read tagged");
   endtask

   task automatic t_partial;
      xfer(1'b1, 12'h020, 32'h1234_5678, 4'h3, 3'b000, 1'b0);
      chk_counts("R7 partial write");
      xfer(1'b1, 12'h024, 32'h0BAD_F00D, 4'h0, 3'b001, 1'b0);
      chk_counts("R7/R8 zero-strobe tagged write");
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 20; i++)
         xfer(1'b1, 12'(i * 4), 32'(i), 4'h8, 3'b010, 1'b0);
      chk_counts("R9 saturation");
      chk(cp0 == 4'hF, "R9 u0 stuck at top", 64'(cp0), 64'hF);
   endtask

   task automatic t_clear;
      xfer(1'b1, 12'h100, 32'h5555_AAAA, 4'h1, 3'b011, 1'b1);
      chk_counts("R10 clear beats increment");
      xfer(1'b1, 12'h104, 32'hAAAA_5555, 4'hE, 3'b000, 1'b0);
      chk_counts("R10 count resumes after clear");
   endtask

   initial begin
      t_reset();
      t_full_write();
      t_read();
      t_partial();
      t_saturate();
      t_clear();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule